// File: doc/BRIEF.md
# Time-Multiplexed Pseudo Dual-Port RAM

This block offers two memory ports on top of one single-port synchronous array. Port A may read or write and port B may only read. The core clock runs at twice the access rate, and a two-state slot machine hands the array to port A in one cycle and to port B in the next. Together the two cycles form one access period. Port B gets its read in every period, even when port A writes in the same period, so there is no stall of the kind that a duplicated-array scheme would cause.

Both ports present their requests during a cycle in which `accept` is high. The requests are sampled on the clock edge that ends that cycle. The slot machine has two states. In `SLOT_A` the array is addressed by port A: the write address when A writes, otherwise the read address. In `SLOT_B` the array is addressed by port B's read address. There are two transitions: `SLOT_A -> SLOT_B` on every edge that is not in reset, and `SLOT_B -> SLOT_A` on every edge, which is also the sampling edge. Reset forces `SLOT_A`.

If port A writes and port B reads the same address in one period, B's slot comes after A's write, so B returns the newly written word. A one-cycle `collision` pulse reports the case.

Top module: `tdm_dpram`

## Requirements
- R1: A synchronous active-high `rst` puts the slot machine in `SLOT_A`, so `accept` is 0 in the first cycle after release. It also clears `a_rdata`, `b_rdata` and `collision` to 0.
- R2: After reset, `accept` is high in every second cycle, in the `SLOT_B` state, starting with the second cycle after release.
- R3: A request with `a_en`=1 and `a_we`=1, sampled at the end of an `accept` cycle, writes `a_wdata` to `a_waddr`. The new word is seen by every later read of that address on either port.
- R4: A request with `a_en`=1 and `a_we`=0 updates `a_rdata` to the word at `a_raddr` on the second clock edge after the sampling edge.
- R5: A request with `b_en`=1 updates `b_rdata` to the word at `b_raddr` on the third clock edge after the sampling edge. This holds in every period, including periods in which port A writes.
- R6: When A writes and B reads the same address in one period, `b_rdata` returns the newly written data.
- R7: `collision` is 1 for exactly the one cycle after a sampling edge at which `a_en`, `a_we` and `b_en` were all 1 and `a_waddr` equalled `b_raddr`. It is 0 at all other times.
- R8: Input values present in cycles where `accept` is 0 have no effect on the memory or on any output.
- R9: A port whose enable was 0 in a period keeps its read data unchanged. Port A with `a_en`=0 does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the access rate |
| rst | input | 1 | Synchronous active-high reset |
| accept | output | 1 | High in the cycle whose closing edge samples both ports' requests |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_waddr | input | ADDR_W | Port A write address |
| a_raddr | input | ADDR_W | Port A read address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, held between reads |
| b_en | input | 1 | Port B read enable |
| b_raddr | input | ADDR_W | Port B read address |
| b_rdata | output | DATA_W | Port B read data, held between reads |
| collision | output | 1 | One-cycle pulse on a same-address A write and B read |

## Verification
Let the sampling edge be edge 0. `collision` is due in the cycle that follows edge 0. `a_rdata` is due after edge 2, which is also the next sampling edge. `b_rdata` is due after edge 3. The bench drives each request at the falling edge inside an `accept` cycle. In the next slot-A cycle it compares `collision` for that request and `a_rdata` for the previous request. At the next `accept` falling edge it compares `b_rdata` for the request before the previous one. Between requests it drives random junk during slot A, which must leave every result unchanged.

// File: rtl/tdm_dpram_pkg.sv
package tdm_dpram_pkg;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

endpackage

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_dpram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  accept
);

    slot_e state_q;
    slot_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_A:  state_d = SLOT_B;
            SLOT_B:  state_d = SLOT_A;
            default: state_d = SLOT_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        slot   = state_q;
        accept = 1'b0;
        unique case (state_q)
            SLOT_A:  accept = 1'b0;
            SLOT_B:  accept = 1'b1;
            default: accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/tdm_req_reg.sv
module tdm_req_reg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic              a_en_q,
    output logic              a_we_q,
    output logic [ADDR_W-1:0] a_waddr_q,
    output logic [ADDR_W-1:0] a_raddr_q,
    output logic [DATA_W-1:0] a_wdata_q,
    output logic              b_en_q,
    output logic [ADDR_W-1:0] b_raddr_q,
    output logic              coll_q
);

    logic same_loc;

    always_comb begin
        same_loc = a_en && a_we && b_en && (a_waddr == b_raddr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_en_q    <= 1'b0;
            a_we_q    <= 1'b0;
            a_waddr_q <= '0;
            a_raddr_q <= '0;
            a_wdata_q <= '0;
            b_en_q    <= 1'b0;
            b_raddr_q <= '0;
            coll_q    <= 1'b0;
        end else if (take) begin
            a_en_q    <= a_en;
            a_we_q    <= a_we;
            a_waddr_q <= a_waddr;
            a_raddr_q <= a_raddr;
            a_wdata_q <= a_wdata;
            b_en_q    <= b_en;
            b_raddr_q <= b_raddr;
            coll_q    <= same_loc;
        end else begin
            coll_q    <= 1'b0;
        end
    end

endmodule

// File: rtl/tdm_sp_ram.sv
module tdm_sp_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/tdm_rd_capture.sv
module tdm_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_match,
    input  logic              pend_set,
    input  logic              pend_upd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            dout   <= '0;
        end else begin
            if (pend_upd) begin
                pend_q <= pend_set;
            end
            if (slot_match && pend_q) begin
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/tdm_dpram.sv
module tdm_dpram
    import tdm_dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              accept,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [DATA_W-1:0] b_rdata,
    output logic              collision
);

    localparam int NPORT = 2;

    slot_e             slot;
    logic              a_en_q;
    logic              a_we_q;
    logic [ADDR_W-1:0] a_waddr_q;
    logic [ADDR_W-1:0] a_raddr_q;
    logic [DATA_W-1:0] a_wdata_q;
    logic              b_en_q;
    logic [ADDR_W-1:0] b_raddr_q;
    logic              coll_q;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rdata;
    logic [NPORT-1:0]  cap_slot;
    logic [NPORT-1:0]  cap_set;
    logic [NPORT-1:0]  cap_upd;
    logic [DATA_W-1:0] cap_out [NPORT];

    tdm_slot_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot),
        .accept (accept)
    );

    tdm_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk       (clk),
        .rst       (rst),
        .take      (accept),
        .a_en      (a_en),
        .a_we      (a_we),
        .a_waddr   (a_waddr),
        .a_raddr   (a_raddr),
        .a_wdata   (a_wdata),
        .b_en      (b_en),
        .b_raddr   (b_raddr),
        .a_en_q    (a_en_q),
        .a_we_q    (a_we_q),
        .a_waddr_q (a_waddr_q),
        .a_raddr_q (a_raddr_q),
        .a_wdata_q (a_wdata_q),
        .b_en_q    (b_en_q),
        .b_raddr_q (b_raddr_q),
        .coll_q    (coll_q)
    );

    // Address and control multiplexer: the slot picks the owner.
    always_comb begin
        arr_addr = b_raddr_q;
        arr_we   = 1'b0;
        unique case (slot)
            SLOT_A: begin
                arr_addr = a_we_q ? a_waddr_q : a_raddr_q;
                arr_we   = a_en_q && a_we_q;
            end
            SLOT_B: begin
                arr_addr = b_raddr_q;
                arr_we   = 1'b0;
            end
            default: begin
                arr_addr = b_raddr_q;
                arr_we   = 1'b0;
            end
        endcase
    end

    tdm_sp_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (a_wdata_q),
        .rdata (arr_rdata)
    );

    // Port 0 (A): array op at the end of slot A, capture at the end of slot B.
    // Port 1 (B): array op at the end of slot B, capture at the end of slot A.
    always_comb begin
        cap_slot[0] = (slot == SLOT_B);
        cap_upd[0]  = (slot == SLOT_A);
        cap_set[0]  = a_en_q && !a_we_q;
        cap_slot[1] = (slot == SLOT_A);
        cap_upd[1]  = (slot == SLOT_B);
        cap_set[1]  = b_en_q;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_cap
        tdm_rd_capture #(
            .DATA_W (DATA_W)
        ) u_cap (
            .clk        (clk),
            .rst        (rst),
            .slot_match (cap_slot[p]),
            .pend_set   (cap_set[p]),
            .pend_upd   (cap_upd[p]),
            .din        (arr_rdata),
            .dout       (cap_out[p])
        );
    end

    always_comb begin
        a_rdata   = cap_out[0];
        b_rdata   = cap_out[1];
        collision = coll_q;
    end

endmodule

// File: rtl/tdm_dpram_chk.sv
module tdm_dpram_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input logic              collision,
    input logic [DATA_W-1:0] a_rdata,
    input logic [DATA_W-1:0] b_rdata
);

    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    // R2
    accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> accept);

    // R7
    collision_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        collision |=> !collision);

    // R7
    collision_slot_chk: assert property (@(posedge clk) disable iff (rst)
        collision |-> !accept);

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(a_rdata));

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> $stable(b_rdata));

endmodule

bind tdm_dpram tdm_dpram_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .collision (collision),
    .a_rdata   (a_rdata),
    .b_rdata   (b_rdata)
);

// File: tb/tdm_dpram_tb.sv
module tdm_dpram_tb;

    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int NRAND = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          accept;
    logic          a_en = 1'b0;
    logic          a_we = 1'b0;
    logic [AW-1:0] a_waddr = '0;
    logic [AW-1:0] a_raddr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic [DW-1:0] a_rdata;
    logic          b_en = 1'b0;
    logic [AW-1:0] b_raddr = '0;
    logic [DW-1:0] b_rdata;
    logic          collision;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] ea_prev;
    logic [DW-1:0] eb_prev1;
    logic [DW-1:0] eb_prev2;
    string         tb_prev1;
    string         tb_prev2;

    always #5 clk = ~clk;

    tdm_dpram #(
        .ADDR_W (AW),
        .DATA_W (DW)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .a_en      (a_en),
        .a_we      (a_we),
        .a_waddr   (a_waddr),
        .a_raddr   (a_raddr),
        .a_wdata   (a_wdata),
        .a_rdata   (a_rdata),
        .b_en      (b_en),
        .b_raddr   (b_raddr),
        .b_rdata   (b_rdata),
        .collision (collision)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One access period with a given request; compares results that fall due.
    task automatic period(input bit ae, input bit awe, input logic [AW-1:0] wa,
                          input logic [AW-1:0] ra, input logic [DW-1:0] wd,
                          input bit be, input logic [AW-1:0] br);
        logic [DW-1:0] ea_k;
        logic [DW-1:0] eb_k;
        bit            coll_k;
        string         tb_k;
        @(negedge clk);
        while (!accept) @(negedge clk);
        check(accept == 1'b1, "R2 accept high", accept, 1);
        check(b_rdata == eb_prev2, tb_prev2, b_rdata, eb_prev2);
        a_en = ae; a_we = awe; a_waddr = wa; a_raddr = ra; a_wdata = wd;
        b_en = be; b_raddr = br;
        // reference model: A acts first, then B reads
        coll_k = ae && awe && be && (wa == br);
        ea_k   = ea_prev;
        if (ae && awe) model[wa] = wd;
        else if (ae) ea_k = model[ra];
        eb_k = eb_prev1;
        tb_k = "R9 b hold";
        if (be) begin
            eb_k = model[br];
            tb_k = coll_k ? "R6 b new data" : ((ae && awe) ? "R5 b read beside write" : "R5 b read");
        end
        @(negedge clk);
        check(accept == 1'b0, "R2 accept low", accept, 0);
        check(a_rdata == ea_prev, "R3 R4 R9 a_rdata", a_rdata, ea_prev);
        check(collision == coll_k, "R7 collision", collision, coll_k);
        // R8: junk during slot A must not be sampled
        a_en = 1'($urandom); a_we = 1'($urandom); a_waddr = AW'($urandom);
        a_raddr = AW'($urandom); a_wdata = DW'($urandom);
        b_en = 1'($urandom); b_raddr = AW'($urandom);
        ea_prev  = ea_k;
        eb_prev2 = eb_prev1;
        eb_prev1 = eb_k;
        tb_prev2 = tb_prev1;
        tb_prev1 = tb_k;
    endtask

    initial begin
        ea_prev = '0; eb_prev1 = '0; eb_prev2 = '0;
        tb_prev1 = "R5 b_rdata"; tb_prev2 = "R5 b_rdata";
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state in the first cycle after release
        check(accept == 1'b0, "R1 accept", accept, 0);
        check(a_rdata == '0, "R1 a_rdata", a_rdata, 0);
        check(b_rdata == '0, "R1 b_rdata", b_rdata, 0);
        check(collision == 1'b0, "R1 collision", collision, 0);
        // fill every word through port A (R3), B idle
        for (int i = 0; i < DEPTH; i++) begin
            period(1'b1, 1'b1, AW'(i), '0, DW'($urandom), 1'b0, '0);
        end
        // read back on both ports
        for (int i = 0; i < DEPTH; i++) begin
            period(1'b1, 1'b0, '0, AW'(i), '0, 1'b1, AW'(DEPTH - 1 - i));
        end
        // back-to-back writes to one address with B reading it (R6, R7)
        for (int i = 0; i < 8; i++) begin
            period(1'b1, 1'b1, AW'(5), '0, DW'(16'h1000 + i), 1'b1, AW'(5));
        end
        // disabled ports: no write, data held (R9)
        period(1'b0, 1'b1, AW'(5), AW'(5), DW'(16'hdead), 1'b0, AW'(5));
        period(1'b0, 1'b0, '0, '0, '0, 1'b0, '0);
        period(1'b1, 1'b0, '0, AW'(5), '0, 1'b1, AW'(5));
        // random mix
        for (int k = 0; k < NRAND; k++) begin
            logic [AW-1:0] wa;
            logic [AW-1:0] br;
            wa = AW'($urandom);
            br = ($urandom % 4 == 0) ? wa : AW'($urandom);
            period(($urandom % 8) != 0, 1'($urandom), wa, AW'($urandom),
                   DW'($urandom), ($urandom % 8) != 0, br);
        end
        // drain
        period(1'b0, 1'b0, '0, '0, '0, 1'b0, '0);
        period(1'b0, 1'b0, '0, '0, '0, 1'b0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule